// File: doc/BRIEF.md
# Dual 16-bit Multi-Mode Timer

This block holds two 16-bit down-counters and a small set of reload and capture registers. One mode field decides what the pair does: a self-running pulse generator with a spare counter beside it, a two-input time-stamp unit, two separate timers or event counters, or a single time-stamp channel working next to an event counter. Once it is programmed, software is needed only to read captured values or to clear flags.

Software uses a simple synchronous register port, with a write strobe and a read port whose data arrives one clock after the address. A clock-enable input `tick` sets the timing base for the counters. Two event inputs act either as capture triggers or as counting clocks, and the active edge is chosen for each input. The block has one PWM output and one interrupt request. The interrupt is the OR of four pending flags, each of which has its own enable.

Register map (4-bit address): 0 counter 1, 1 counter 2, 2 reload 1A, 3 reload 1B, 4 reload 2, 5 control, 6 interrupt enables, 7 pending flags, 8 capture A, 9 capture B (8 and 9 are read-only). Control bits: [1:0] mode (0 = PWM plus counter, 1 = dual capture, 2 = dual timer, 3 = capture plus timer), [2] counter 1 steps on `evt_a` edges instead of `tick`, [3] counter 2 steps on `evt_b` edges instead of `tick`, [4] `evt_a` active edge is falling, [5] `evt_b` active edge is falling, [6] run. Flag bits: 0 counter 1 underflow, 1 counter 2 underflow, 2 capture A, 3 capture B.

Top module: `dual_mode_timer`

## Requirements
- R1: After synchronous reset every register reads 0, and `pwm_out` and `irq` are low.
- R2: With run set, a counter takes a step whenever its step source fires, and it never steps while that source is idle (`tick` low). A step at value 0 reloads the counter and sets its underflow flag (bit 0 for counter 1, bit 1 for counter 2). Any other step decrements by one. Counter 1 reloads from reload 1A and counter 2 from reload 2.
- R3: In mode 0, `pwm_out` toggles at each underflow of counter 1. When it goes high, counter 1 reloads from 1A, and when it goes low, from 1B. The result is a high time of 1A+1 and a low time of 1B+1 `tick` cycles. In every other mode `pwm_out` is held low.
- R4: In mode 0, counter 2 runs as an independent counter from reload 2 on its selected step source.
- R5: In mode 1, counter 1 steps on `tick`. An active edge on `evt_a` copies counter 1 into capture A and sets flag 2. An active edge on `evt_b` copies counter 1 into capture B and sets flag 3. Counter 2 holds its value.
- R6: In mode 2, control bit 2 makes counter 1 step once per active `evt_a` edge, and bit 3 does the same for counter 2 on `evt_b`. `tick` then has no effect on that counter.
- R7: In mode 3, counter 1 steps on `tick` and captures on `evt_a` as in mode 1. Counter 2 steps on each active `evt_b` edge, and capture B and flag 3 stay untouched.
- R8: Control bits 4 and 5 select the falling edge for the active edge of `evt_a` and `evt_b`. When a bit is 0, the rising edge is active and a falling edge does nothing.
- R9: Writing 1s to address 7 clears those flags. `irq` is high one clock after any flag is both pending and enabled, and low one clock after none is.
- R10: Writes take effect at the clock edge of the strobe, and a counter write overrides that counter's step in the same cycle. `rd_data` shows the addressed register one clock after `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable for counters stepping on the time base |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | W | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | W | Registered read data |
| evt_a | input | 1 | Event / capture input A |
| evt_b | input | 1 | Event / capture input B |
| pwm_out | output | 1 | Registered PWM output |
| irq | output | 1 | Registered interrupt request |

## Verification
A bad reload choice or an off-by-one in the counter shows up on `pwm_out` within one PWM period, as a high or low phase that is one tick too long or too short. A wrong underflow detect shifts the rise of `irq`, which is registered, away from the cycle count that follows from the loaded value plus two. A capture taken from the wrong counter, at the wrong edge, or one cycle late changes the difference between the two capture registers. That difference is readable as soon as the second event has been seen. Event counts that go astray, or a counter that is not properly frozen, show up in the counter value read back right after a burst of pulses.

// File: rtl/mmt_pkg.sv
`timescale 1ns/1ps
package mmt_pkg;

  typedef enum logic [1:0] {
    MODE_PWM    = 2'd0,
    MODE_CAP2   = 2'd1,
    MODE_TMR2   = 2'd2,
    MODE_CAPTMR = 2'd3
  } mmt_mode_e;

  // control word, MSB first
  typedef struct packed {
    logic      run;
    logic      fall_b;
    logic      fall_a;
    logic      sel2_evt;
    logic      sel1_evt;
    mmt_mode_e mode;
  } mmt_ctrl_t;

  localparam int CTRL_W = $bits(mmt_ctrl_t);
  localparam int NFLAG  = 4;

  // flag positions
  localparam int F_UNF1 = 0;
  localparam int F_UNF2 = 1;
  localparam int F_CAPA = 2;
  localparam int F_CAPB = 3;

  // register addresses
  localparam int A_CNT1 = 0;
  localparam int A_CNT2 = 1;
  localparam int A_R1A  = 2;
  localparam int A_R1B  = 3;
  localparam int A_R2   = 4;
  localparam int A_CTRL = 5;
  localparam int A_IEN  = 6;
  localparam int A_PEND = 7;
  localparam int A_CAPA = 8;
  localparam int A_CAPB = 9;

endpackage

// File: rtl/mmt_edge.sv
`timescale 1ns/1ps
module mmt_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  input  logic [N-1:0] fall,
  output logic [N-1:0] hit
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= din;
  end

  for (genvar i = 0; i < N; i++) begin : g_det
    always_comb begin
      if (fall[i]) hit[i] = prev[i] & ~din[i];
      else         hit[i] = din[i] & ~prev[i];
    end
  end
endmodule

// File: rtl/mmt_counter.sv
`timescale 1ns/1ps
module mmt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         unf
);
  logic at_zero;

  always_comb begin
    at_zero = (cnt == '0);
    unf     = step && !wr && at_zero;
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wr)   cnt <= wr_val;
    else if (step) cnt <= at_zero ? reload : cnt - W'(1);
  end
endmodule

// File: rtl/mmt_flags.sv
`timescale 1ns/1ps
module mmt_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] ien,
  output logic [N-1:0] pend,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= (pend & ~clr) | set;
      irq  <= |(pend & ien);
    end
  end
endmodule

// File: rtl/dual_mode_timer.sv
`timescale 1ns/1ps
module dual_mode_timer
  import mmt_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          evt_a,
  input  logic          evt_b,
  output logic          pwm_out,
  output logic          irq
);
  localparam int PADC = W - CTRL_W;
  localparam int PADF = W - NFLAG;

  mmt_ctrl_t        ctrl;
  logic [W-1:0]     rel1a, rel1b, rel2, cap_a, cap_b;
  logic [NFLAG-1:0] ien, pend, fset, fclr;
  logic [W-1:0]     cnt1, cnt2, reload1;
  logic             unf1, unf2, step1, step2;
  logic             wr_cnt1, wr_cnt2;
  logic             capa_hit, capb_hit;
  logic [1:0]       edg;

  // ---------------- register writes ----------------
  always_comb begin
    wr_cnt1 = wr_en && (wr_addr == AW'(A_CNT1));
    wr_cnt2 = wr_en && (wr_addr == AW'(A_CNT2));
    fclr    = (wr_en && (wr_addr == AW'(A_PEND))) ? wr_data[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      rel1a <= '0;
      rel1b <= '0;
      rel2  <= '0;
      ien   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        AW'(A_R1A):  rel1a <= wr_data;
        AW'(A_R1B):  rel1b <= wr_data;
        AW'(A_R2):   rel2  <= wr_data;
        AW'(A_CTRL): ctrl  <= mmt_ctrl_t'(wr_data[CTRL_W-1:0]);
        AW'(A_IEN):  ien   <= wr_data[NFLAG-1:0];
        default: ;
      endcase
    end
  end

  // ---------------- event edges ----------------
  mmt_edge #(.N(2)) u_edge (
    .clk (clk),
    .rst (rst),
    .din ({evt_b, evt_a}),
    .fall({ctrl.fall_b, ctrl.fall_a}),
    .hit (edg)
  );

  // ---------------- mode steering ----------------
  always_comb begin
    step1    = ctrl.run && ((ctrl.mode == MODE_TMR2 && ctrl.sel1_evt) ? edg[0] : tick);
    step2    = 1'b0;
    capa_hit = 1'b0;
    capb_hit = 1'b0;
    case (ctrl.mode)
      MODE_PWM, MODE_TMR2: step2 = ctrl.run && (ctrl.sel2_evt ? edg[1] : tick);
      MODE_CAP2: begin
        capa_hit = edg[0];
        capb_hit = edg[1];
      end
      MODE_CAPTMR: begin
        step2    = ctrl.run && edg[1];
        capa_hit = edg[0];
      end
      default: ;
    endcase
    reload1 = (ctrl.mode == MODE_PWM && pwm_out) ? rel1b : rel1a;
  end

  mmt_counter #(.W(W)) u_cnt1 (
    .clk(clk), .rst(rst), .step(step1), .wr(wr_cnt1),
    .wr_val(wr_data), .reload(reload1), .cnt(cnt1), .unf(unf1)
  );

  mmt_counter #(.W(W)) u_cnt2 (
    .clk(clk), .rst(rst), .step(step2), .wr(wr_cnt2),
    .wr_val(wr_data), .reload(rel2), .cnt(cnt2), .unf(unf2)
  );

  // ---------------- capture and PWM ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_a   <= '0;
      cap_b   <= '0;
      pwm_out <= 1'b0;
    end else begin
      if (capa_hit) cap_a <= cnt1;
      if (capb_hit) cap_b <= cnt1;
      if (ctrl.mode != MODE_PWM) pwm_out <= 1'b0;
      else if (unf1)             pwm_out <= ~pwm_out;
    end
  end

  // ---------------- flags / interrupt ----------------
  always_comb begin
    fset         = '0;
    fset[F_UNF1] = unf1;
    fset[F_UNF2] = unf2;
    fset[F_CAPA] = capa_hit;
    fset[F_CAPB] = capb_hit;
  end

  mmt_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set(fset), .clr(fclr),
    .ien(ien), .pend(pend), .irq(irq)
  );

  // ---------------- read port ----------------
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        AW'(A_CNT1): rd_data <= cnt1;
        AW'(A_CNT2): rd_data <= cnt2;
        AW'(A_R1A):  rd_data <= rel1a;
        AW'(A_R1B):  rd_data <= rel1b;
        AW'(A_R2):   rd_data <= rel2;
        AW'(A_CTRL): rd_data <= {{PADC{1'b0}}, ctrl};
        AW'(A_IEN):  rd_data <= {{PADF{1'b0}}, ien};
        AW'(A_PEND): rd_data <= {{PADF{1'b0}}, pend};
        AW'(A_CAPA): rd_data <= cap_a;
        AW'(A_CAPB): rd_data <= cap_b;
        default:     rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mmt_checker.sv
`timescale 1ns/1ps
module mmt_checker #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    mode,
  input logic [W-1:0]  cnt1,
  input logic [W-1:0]  cap_a,
  input logic          edge_a,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          pwm_out,
  input logic [3:0]    pend,
  input logic [3:0]    ien,
  input logic          irq
);
  // R3: outside mode 0 the output is driven low
  a_r3_pwm_low_elsewhere: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd0) |=> !pwm_out);

  // R3: the output only moves when counter 1 is at zero
  a_r3_pwm_toggles_at_zero: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && cnt1 != '0) |=> $stable(pwm_out));

  // R2: a nonzero counter either holds or drops by exactly one
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && wr_addr == AW'(0)) && cnt1 != '0)
      |=> (cnt1 == $past(cnt1) || cnt1 == $past(cnt1) - W'(1)));

  // R5 / R7: an active edge A in a capture mode stores counter 1 and flags it
  a_r5_capture_a: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'd1 || mode == 2'd3) && edge_a) |=> (cap_a == $past(cnt1) && pend[2]));

  // R9: the request follows enabled pending flags one cycle later
  a_r9_irq_raise: assert property (@(posedge clk) disable iff (rst)
    ((pend & ien) != 4'd0) |=> irq);

  a_r9_irq_drop: assert property (@(posedge clk) disable iff (rst)
    ((pend & ien) == 4'd0) |=> !irq);
endmodule

bind dual_mode_timer mmt_checker #(.W(W), .AW(AW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .mode   (ctrl.mode),
  .cnt1   (cnt1),
  .cap_a  (cap_a),
  .edge_a (edg[0]),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .pwm_out(pwm_out),
  .pend   (pend),
  .ien    (ien),
  .irq    (irq)
);

// File: tb/dual_mode_timer_test.sv
`timescale 1ns/1ps
module dual_mode_timer_test;
  localparam int W  = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [W-1:0]  rd_data;
  logic          evt_a = 1'b0;
  logic          evt_b = 1'b0;
  logic          pwm_out;
  logic          irq;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  dual_mode_timer #(.W(W), .AW(AW)) uut (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_a(evt_a), .evt_b(evt_b),
    .pwm_out(pwm_out), .irq(irq)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = AW'(a);
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic pulse_a();
    evt_a = 1'b1; @(negedge clk); evt_a = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_b();
    evt_b = 1'b1; @(negedge clk); evt_b = 1'b0; @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int v, n, old;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 10; a++) begin
      rd(a, v);
      check("R1 reset register", v, 0);
    end
    check("R1 pwm after reset", int'(pwm_out), 0);
    check("R1 irq after reset", int'(irq), 0);

    // R10: register write and readback
    wr(2, 16'hA5C3); rd(2, v); check("R10 reload 1A readback", v, 16'hA5C3);
    wr(3, 16'h3C5A); rd(3, v); check("R10 reload 1B readback", v, 16'h3C5A);
    wr(4, 16'h0F0F); rd(4, v); check("R10 reload 2 readback", v, 16'h0F0F);

    // R2: counter 1 in dual timer mode, latency to irq and reload value
    for (int c = 0; c < 6; c++) begin
      tick = 1'b0;
      wr(5, 8'h02); wr(6, 1); wr(7, 15);
      wr(2, c + 2); wr(0, c);
      tick = 1'b1;
      wr(5, 8'h42);
      n = 0;
      while (!irq) begin @(negedge clk); n++; end
      check("R2 counter 1 underflow latency", n, c + 2);
      tick = 1'b0;
      rd(0, v);
      check("R2 counter 1 reload then one step", v, c + 1);
    end

    // R4: counter 2 in PWM mode on tick
    for (int c = 0; c < 6; c++) begin
      tick = 1'b0;
      wr(5, 8'h00); wr(6, 2); wr(7, 15);
      wr(4, 2 * c + 1); wr(1, c);
      tick = 1'b1;
      wr(5, 8'h40);
      n = 0;
      while (!irq) begin @(negedge clk); n++; end
      check("R4 counter 2 underflow latency", n, c + 2);
      tick = 1'b0;
      rd(1, v);
      check("R4 counter 2 reload then one step", v, 2 * c);
    end

    // R2: no step while tick is low
    tick = 1'b0;
    wr(5, 8'h02); wr(0, 77); wr(5, 8'h42);
    repeat (5) @(negedge clk);
    rd(0, v); check("R2 counter frozen with tick low", v, 77);

    // R3: PWM high and low times, swept
    tick = 1'b1;
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        wr(5, 8'h02); wr(2, a); wr(3, b); wr(0, 0);
        wr(5, 8'h40);
        while (pwm_out == 1'b0) @(negedge clk);
        n = 0; while (pwm_out == 1'b1) begin n++; @(negedge clk); end
        check("R3 pwm high time", n, a + 1);
        n = 0; while (pwm_out == 1'b0) begin n++; @(negedge clk); end
        check("R3 pwm low time", n, b + 1);
        n = 0; while (pwm_out == 1'b1) begin n++; @(negedge clk); end
        check("R3 pwm high time again", n, a + 1);
      end
    end
    wr(5, 8'h42);
    repeat (3) @(negedge clk);
    check("R3 pwm low outside mode 0", int'(pwm_out), 0);

    // R6: event-clocked counters in dual timer mode
    wr(5, 8'h0E); wr(0, 100); wr(1, 200); wr(5, 8'h4E);
    repeat (5) pulse_a();
    repeat (3) pulse_b();
    repeat (4) @(negedge clk);
    rd(0, v); check("R6 counter 1 counts evt_a edges", v, 95);
    rd(1, v); check("R6 counter 2 counts evt_b edges", v, 197);

    // R10: counter write overrides the running step
    wr(5, 8'h42);
    wr(0, 16'h1234);
    rd(0, v); check("R10 counter write wins over step", v, 16'h1234);

    // R5: dual capture, time between events
    wr(5, 8'h01); wr(2, 16'hFFFF); wr(0, 16'hFFFF); wr(1, 50); wr(7, 15);
    wr(5, 8'h41);
    for (int d = 1; d <= 12; d++) begin
      evt_a = 1'b1;
      repeat (d) @(negedge clk);
      evt_b = 1'b1;
      @(negedge clk);
      evt_a = 1'b0; evt_b = 1'b0;
      @(negedge clk);
      rd(8, old); rd(9, v);
      check("R5 capture A minus capture B", old - v, d);
      rd(7, v); check("R5 capture flags set", v & 12, 12);
      wr(7, 12);
    end
    rd(1, v); check("R5 counter 2 holds in dual capture", v, 50);

    // R8: falling-edge selection on evt_a
    wr(5, 8'h51); wr(7, 15);
    rd(8, old);
    evt_a = 1'b1;
    repeat (3) @(negedge clk);
    rd(7, v); check("R8 rising edge ignored when falling selected", v & 4, 0);
    rd(8, v); check("R8 capture A unchanged on rising edge", v, old);
    evt_a = 1'b0;
    repeat (2) @(negedge clk);
    rd(7, v); check("R8 falling edge captures", v & 4, 4);

    // R7: capture plus timer, counter 2 counts evt_b, no capture B
    wr(5, 8'h03); wr(1, 40); wr(7, 15);
    rd(9, old);
    wr(5, 8'h43);
    repeat (4) pulse_b();
    rd(1, v); check("R7 counter 2 counts evt_b", v, 36);
    rd(9, v); check("R7 capture B untouched", v, old);
    rd(7, v); check("R7 flag 3 not set", v & 8, 0);
    pulse_a();
    rd(7, v); check("R7 capture A still active", v & 4, 4);

    // R9: masking and clearing
    wr(6, 0);
    repeat (3) @(negedge clk);
    check("R9 irq low when flags masked", int'(irq), 0);
    wr(6, 4);
    repeat (2) @(negedge clk);
    check("R9 irq high with enabled flag", int'(irq), 1);
    wr(7, 4);
    rd(7, v); check("R9 flag cleared by write of one", v & 4, 0);
    repeat (2) @(negedge clk);
    check("R9 irq low after clear", int'(irq), 0);

    finish_run();
  end
endmodule